// File: doc/BRIEF.md
# Dual-Producer Serial Data Buffer

This block is the character store that sits between a serial port's shift logic and the rest of the chip. Two producers write into one shared store: a processor register path and a DMA channel. One consumer drains it. The same module serves both directions. Built 8 bits wide, it holds transmit characters. Built 11 bits wide, it holds received characters, and the three upper bits carry that character's error flags. The block treats every bit of a word alike.

A runtime mode input picks how the store behaves. With the input high, the store is a first-in first-out queue of `DEPTH` entries (16 by default). With the input low, it becomes a single holding register that reports itself full after one write. Any change of the mode input empties the store. Two status outputs tell a DMA engine whether it may write and whether there is something to read.

Only one word enters the store per cycle. When both producers write in the same cycle, the DMA word goes first. The processor word is parked and written in the following cycle.

Top module: `sbuf_fifo`

## Requirements
- R1: While reset is applied and after it is released, `data_avail`=0, `room_avail`=1, `overflow`=0, `cpu_held`=0 and `rd_data`=0.
- R2: With `fifo_en`=1 the store keeps up to `DEPTH` words and returns them in write order. `room_avail` falls in the cycle after the `DEPTH`-th accepted write.
- R3: With `fifo_en`=0 the store keeps one word. `room_avail` falls in the cycle after a single accepted write and rises again after that word is read.
- R4: Both producers write to the same store. On a same-cycle request, the DMA word is taken first and `cpu_held` is 1 in the next cycle. The parked processor word is then written in the first following cycle that has no DMA request, and `cpu_held` returns to 0 after that cycle.
- R5: A processor write requested while `cpu_held`=1 is discarded.
- R6: A write that reaches the store while it is full is dropped. `overflow` is 1 in the following cycle, for one cycle per dropped write.
- R7: A read requested while the store is empty leaves `rd_data` unchanged.
- R8: An accepted read presents the oldest word on `rd_data` in the cycle after the request.
- R9: A read and a write in the same cycle on a store that is neither empty nor full leave the occupancy unchanged. The write test uses the occupancy before the read.
- R10: In the cycle where `fifo_en` differs from its previous value, all stored words and any parked processor word are discarded. Every request in that cycle is ignored. `rd_data` keeps its value.
- R11: `room_avail` is 1 exactly when occupancy is below capacity (`DEPTH` or 1, depending on the mode). `data_avail` is 1 exactly when occupancy is above zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_en | input | 1 | 1: queue of DEPTH words, 0: single holding register |
| cpu_wr | input | 1 | Processor write request |
| cpu_wdata | input | DATA_W | Processor write word |
| dma_wr | input | 1 | DMA write request (wins on conflict) |
| dma_wdata | input | DATA_W | DMA write word |
| rd_en | input | 1 | Consumer read request |
| rd_data | output | DATA_W | Last word read, registered |
| room_avail | output | 1 | Store can accept a word |
| data_avail | output | 1 | Store holds at least one word |
| overflow | output | 1 | One-cycle pulse per dropped write |
| cpu_held | output | 1 | A processor word is parked behind a DMA write |

## Verification
The bench fills the queue through DMA alone to the boundary and one word past it, then drains it one read past empty. This separates the depth limit, the overflow pulse and the behaviour of a read on an empty store. Interleaved processor and DMA bursts, including back-to-back DMA while a word is parked, show whether the arbitration order and the parking rule hold. Simultaneous reads and writes at partial fill show that occupancy does not drift. Mode flips with data and a parked word present, followed by single-entry traffic and a long pseudo-random stretch, separate the flush from the holding-register capacity.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  // capacity of the store for the current mode
  function automatic int unsigned sbuf_cap(input logic en, input int unsigned depth);
    return en ? depth : 1;
  endfunction
endpackage

// File: rtl/sbuf_wr_arb.sv
module sbuf_wr_arb #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              wr_req,
  output logic [DATA_W-1:0] wr_data,
  output logic              held
);
  logic              hold_v_q, hold_v_d;
  logic [DATA_W-1:0] hold_w_q, hold_w_d;
  logic              hold_ce;

  always_comb begin
    wr_req   = 1'b0;
    wr_data  = dma_wdata;
    hold_v_d = hold_v_q;
    hold_w_d = hold_w_q;
    if (flush) begin
      hold_v_d = 1'b0;
    end else if (dma_wr) begin
      wr_req = 1'b1;
      if (cpu_wr && !hold_v_q) begin
        hold_v_d = 1'b1;
        hold_w_d = cpu_wdata;
      end
    end else if (hold_v_q) begin
      wr_req   = 1'b1;
      wr_data  = hold_w_q;
      hold_v_d = 1'b0;
    end else if (cpu_wr) begin
      wr_req  = 1'b1;
      wr_data = cpu_wdata;
    end
  end

  assign hold_ce = (hold_v_d != hold_v_q) || (hold_w_d != hold_w_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
    end else if (hold_ce) begin
      hold_v_q <= hold_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_ce) hold_w_q <= hold_w_d;
  end

  assign held = hold_v_q;
endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fifo_en,
  input  logic                     wr_req,
  input  logic                     rd_en,
  output logic                     flush,
  output logic                     wr_go,
  output logic                     rd_go,
  output logic [$clog2(DEPTH)-1:0] waddr,
  output logic [$clog2(DEPTH)-1:0] raddr,
  output logic                     room,
  output logic                     avail,
  output logic                     ovf
);
  import sbuf_pkg::*;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          mode_q;
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d, cap;
  logic          ovf_q, ovf_d;

  assign flush = (fifo_en != mode_q);
  assign cap   = CW'(sbuf_cap(mode_q, DEPTH));
  assign room  = (cnt_q < cap);
  assign avail = (cnt_q != '0);
  assign wr_go = wr_req && room && !flush;
  assign rd_go = rd_en && avail && !flush;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    ovf_d = wr_req && !room && !flush;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (wr_go) wp_d = wp_q + AW'(1);
      if (rd_go) rp_d = rp_q + AW'(1);
      case ({wr_go, rd_go})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      mode_q <= fifo_en;
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  assign waddr = wp_q;
  assign raddr = rp_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/sbuf_store.sv
module sbuf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_go,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_go,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rd_data
);
  logic [DATA_W-1:0] row_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic row_ce;
    assign row_ce = wr_go && (waddr == i[$clog2(DEPTH)-1:0]);
    always_ff @(posedge clk) begin
      if (row_ce) row_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_go) begin
      rd_data <= row_q[raddr];
    end
  end
endmodule

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              room_avail,
  output logic              data_avail,
  output logic              overflow,
  output logic              cpu_held
);
  localparam int AW = $clog2(DEPTH);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              flush, wr_req, wr_go, rd_go;
  logic [DATA_W-1:0] wr_data;
  logic [AW-1:0]     waddr, raddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  sbuf_wr_arb #(.DATA_W(DATA_W)) arb_i (
    .clk(clk), .rst_n(rst_n_s), .flush(flush),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .dma_wr(dma_wr), .dma_wdata(dma_wdata),
    .wr_req(wr_req), .wr_data(wr_data), .held(cpu_held)
  );

  sbuf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n_s), .fifo_en(fifo_en),
    .wr_req(wr_req), .rd_en(rd_en), .flush(flush),
    .wr_go(wr_go), .rd_go(rd_go), .waddr(waddr), .raddr(raddr),
    .room(room_avail), .avail(data_avail), .ovf(overflow)
  );

  sbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n_s), .wr_go(wr_go), .waddr(waddr),
    .wr_data(wr_data), .rd_go(rd_go), .raddr(raddr), .rd_data(rd_data)
  );
endmodule

// File: rtl/sbuf_fifo_chk.sv
module sbuf_fifo_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              fifo_en,
  input logic              flush,
  input logic              cpu_wr,
  input logic              dma_wr,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              room_avail,
  input logic              data_avail,
  input logic              overflow,
  input logic              cpu_held
);
  AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n_s)
    overflow |-> $past(!room_avail)); // R6
  AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && !data_avail) |=> $stable(rd_data)); // R7
  AST_STATUS_NEVER_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (room_avail || data_avail)); // R11
  AST_CONFLICT_PARKS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dma_wr && cpu_wr && !cpu_held && !flush) |=> cpu_held); // R4
  AST_PARK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_held && !dma_wr) |=> !cpu_held); // R4
  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush |=> (!data_avail && !cpu_held)); // R10
  AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!fifo_en && !flush && data_avail) |-> !room_avail); // R3
endmodule

bind sbuf_fifo sbuf_fifo_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n_s(rst_n_s), .fifo_en(fifo_en), .flush(flush),
  .cpu_wr(cpu_wr), .dma_wr(dma_wr), .rd_en(rd_en), .rd_data(rd_data),
  .room_avail(room_avail), .data_avail(data_avail),
  .overflow(overflow), .cpu_held(cpu_held)
);

// File: tb/sbuf_fifo_tb.sv
`timescale 1ns/1ps
module sbuf_fifo_tb_top;
  localparam int DW = 11;
  localparam int DP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fifo_en = 1'b1;
  logic          cpu_wr = 1'b0, dma_wr = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] cpu_wdata = '0, dma_wdata = '0;
  logic [DW-1:0] rd_data;
  logic          room_avail, data_avail, overflow, cpu_held;

  int n_chk = 0, n_fail = 0;

  // reference model state
  logic [DW-1:0] q[$];
  logic          m_en = 1'b1, m_hold = 1'b0, m_ovf = 1'b0;
  logic [DW-1:0] m_hold_w = '0, m_rd = '0;

  always #4 clk = ~clk;

  sbuf_fifo #(.DATA_W(DW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .dma_wr(dma_wr), .dma_wdata(dma_wdata),
    .rd_en(rd_en), .rd_data(rd_data), .room_avail(room_avail),
    .data_avail(data_avail), .overflow(overflow), .cpu_held(cpu_held)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model_step();
    logic          wreq = 1'b0;
    logic [DW-1:0] wd = '0;
    int            cap;
    logic          rok, wok;
    m_ovf = 1'b0;
    if (fifo_en != m_en) begin
      m_en = fifo_en; q.delete(); m_hold = 1'b0;   // R10
      return;
    end
    if (dma_wr) begin
      wreq = 1'b1; wd = dma_wdata;
      if (cpu_wr && !m_hold) begin m_hold = 1'b1; m_hold_w = cpu_wdata; end
    end else if (m_hold) begin
      wreq = 1'b1; wd = m_hold_w; m_hold = 1'b0;
    end else if (cpu_wr) begin
      wreq = 1'b1; wd = cpu_wdata;
    end
    cap = m_en ? DP : 1;
    rok = rd_en && (q.size() > 0);
    wok = wreq && (q.size() < cap);
    m_ovf = wreq && !wok;
    if (rok) m_rd = q.pop_front();
    if (wok) q.push_back(wd);
  endfunction

  function automatic int m_room();
    return (q.size() < (m_en ? DP : 1)) ? 1 : 0;
  endfunction

  task automatic compare_all();
    chk("R8", "rd_data", int'(rd_data), int'(m_rd));
    chk("R11", "room_avail", int'(room_avail), m_room());
    chk("R11", "data_avail", int'(data_avail), (q.size() > 0) ? 1 : 0);
    chk("R6", "overflow", int'(overflow), int'(m_ovf));
    chk("R4", "cpu_held", int'(cpu_held), int'(m_hold));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    cpu_wr = 1'b0; dma_wr = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "data_avail", int'(data_avail), 0);
    chk("R1", "room_avail", int'(room_avail), 1);
    chk("R1", "rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc();
    chk("R1", "overflow", int'(overflow), 0);
    chk("R1", "cpu_held", int'(cpu_held), 0);

    // R2 fill through DMA, one past full (R6)
    for (int i = 0; i < DP + 1; i++) begin
      dma_wr = 1'b1; dma_wdata = DW'(100 + i); cyc();
    end
    idle_inputs();
    chk("R2", "room after depth", int'(room_avail), 1'b0);
    chk("R6", "overflow pulse", int'(overflow), 1);
    cyc();
    chk("R6", "overflow one cycle", int'(overflow), 0);
    // drain, in order (R2, R8), one past empty (R7)
    for (int i = 0; i < DP; i++) begin
      rd_en = 1'b1; cyc();
      chk("R2", "order", int'(rd_data), 100 + i);
    end
    keep = rd_data;
    rd_en = 1'b1; cyc(); cyc();
    chk("R7", "empty read keeps", int'(rd_data), int'(keep));
    idle_inputs();

    // R4 conflict: DMA first, CPU parked then written
    dma_wr = 1'b1; dma_wdata = 11'd7; cpu_wr = 1'b1; cpu_wdata = 11'd9; cyc();
    chk("R4", "parked", int'(cpu_held), 1);
    // R5 new CPU while parked with DMA again: CPU discarded
    dma_wdata = 11'd8; cpu_wdata = 11'd55; cyc();
    dma_wr = 1'b0; cpu_wr = 1'b0; cyc();
    chk("R4", "released", int'(cpu_held), 0);
    cpu_wr = 1'b1; cpu_wdata = 11'd66; cyc(); cpu_wr = 1'b0;
    rd_en = 1'b1;
    cyc(); chk("R4", "first dma", int'(rd_data), 7);
    cyc(); chk("R4", "second dma", int'(rd_data), 8);
    cyc(); chk("R4", "parked cpu word", int'(rd_data), 9);
    cyc(); chk("R5", "discarded cpu word skipped", int'(rd_data), 66);
    idle_inputs();

    // R9 simultaneous read/write at partial fill
    for (int i = 0; i < 3; i++) begin dma_wr = 1'b1; dma_wdata = DW'(200 + i); cyc(); end
    for (int i = 0; i < 5; i++) begin
      dma_wr = 1'b1; rd_en = 1'b1; dma_wdata = DW'(300 + i); cyc();
    end
    idle_inputs();
    chk("R9", "still occupied", int'(data_avail), 1);

    // R10 mode flip with data and a parked word, requests in the flip cycle
    dma_wr = 1'b1; cpu_wr = 1'b1; cpu_wdata = 11'd1; dma_wdata = 11'd2; cyc();
    fifo_en = 1'b0; rd_en = 1'b1; dma_wdata = 11'd3; keep = rd_data; cyc();
    idle_inputs();
    chk("R10", "flushed", int'(data_avail), 0);
    chk("R10", "rd_data kept", int'(rd_data), int'(keep));
    chk("R10", "park dropped", int'(cpu_held), 0);

    // R3 holding-register mode
    cpu_wr = 1'b1; cpu_wdata = 11'h5A5; cyc(); cpu_wr = 1'b0;
    chk("R3", "full after one", int'(room_avail), 0);
    dma_wr = 1'b1; dma_wdata = 11'h111; cyc(); dma_wr = 1'b0;
    chk("R3", "second write overflows", int'(overflow), 1);
    rd_en = 1'b1; cyc(); rd_en = 1'b0;
    chk("R3", "held word", int'(rd_data), 11'h5A5);
    chk("R3", "room again", int'(room_avail), 1);

    // pseudo-random traffic across both modes
    for (int i = 0; i < 3000; i++) begin
      dma_wr = ($urandom % 3) == 0;
      cpu_wr = ($urandom % 3) == 0;
      rd_en  = ($urandom % 2) == 0;
      dma_wdata = DW'($urandom);
      cpu_wdata = DW'($urandom);
      if (($urandom % 200) == 0) fifo_en = ~fifo_en;
      cyc();
    end
    idle_inputs();
    cyc();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule